// File: doc/BRIEF.md
# Dual-Channel Disk Interrupt Status Unit

This block keeps the interrupt bookkeeping for a two-channel disk controller. Each channel raises a level-sensitive request line. The block records a pending flag for each channel and combines the unblocked flags into one registered interrupt output. Software sees each pending flag in two configuration-space places: a per-channel byte (0x50 for channel 0, 0x57 for channel 1) and a shared mode byte at 0x71, which also holds one block mask per channel. Both copies are kept identical whichever one software clears.

A second, byte-wide bus-master window gives each channel an 8-byte slice at offset 8·n. The low four bytes of a slice are handled here:
- Byte 0 (command) is forwarded to external logic.
- Byte 1 is an alias of the mode byte. Only its mask bits can be written through this alias.
- Byte 2 (status) is forwarded to external logic.
- Byte 3 holds the channel's transfer-timing register, which is also visible in configuration space at 0x73 or 0x7B.

Window bytes 4 to 7 of a slice belong to logic outside this block. Configuration-space reads, window reads and the forwarding strobes are combinational. All register state changes on the rising clock edge.

Top module: `dual_ide_irq_unit`

## Requirements
- R1: After reset, config byte 0x51 reads 0x04, or 0x0C when the SECONDARY_EN parameter is 1. Bytes 0x50, 0x57, 0x71, 0x73 and 0x7B read 0x00, and irqOut is 0.
- R2: Channel 0 pending is bit 2 of 0x50 and bit 2 of 0x71. Channel 1 pending is bit 4 of 0x57 and bit 3 of 0x71. On any clock edge where a channel's request input is high, its pending bit becomes 1, unless R4 applies. On the edge where the input is first seen low after being high, its pending bit becomes 0.
- R3: A configuration write clears a pending bit when it writes 1 to that bit's position in 0x50, 0x57 or 0x71. Writing 0 to that position has no effect. All other bits of those three bytes, including the mask bits of 0x71, cannot be changed through configuration space.
- R4: A clear by a write of 1 takes priority over a high request input on the same edge. The pending bit reads 0 for one cycle and is set again on the following edge if the input is still high.
- R5: irqOut is registered. It is 1 exactly when some channel is pending while its block mask is 0. The block masks are bit 4 of 0x71 for channel 0 and bit 5 for channel 1. irqOut changes on the same edge as the register state that causes it.
- R6: Window byte 1 of either slice reads the 0x71 byte. A write to it sets both block masks from data bits 5:4 and leaves the pending bits unchanged.
- R7: Window byte 3 of slice n (offset 3 + 8·n) reads and writes timing register n. That register is also visible at config 0x73 for channel 0 and 0x7B for channel 1.
- R8: A write to window byte 0 or byte 2 of slice n pulses fwdCmdWr[n] or fwdStatWr[n] for that cycle, with fwdData carrying the written byte. A read of byte 0 or byte 2 returns byte n of extCmdByte or extStatByte, where byte n means bits 8n+7:8n.
- R9: While bmWide is 1, a window read returns 0xFF and a window write changes nothing and produces no forwarding strobe.
- R10: Config byte 0x51 is a fully writable enable byte. Unmapped config addresses and window bytes 4 to 7 of a slice read 0x00.
- R11: The two copies of each pending bit agree at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| chanIrq | input | 2 | Level request per channel |
| cfgAddr | input | CFG_AW | Configuration byte address, for both read and write |
| cfgWrEn | input | 1 | Configuration byte write strobe |
| cfgWrData | input | 8 | Configuration write data |
| cfgRdData | output | 8 | Configuration read data (combinational) |
| bmAddr | input | WIN_AW | Bus-master window byte address |
| bmWide | input | 1 | Access is wider than one byte |
| bmWrEn | input | 1 | Window write strobe |
| bmWrData | input | 8 | Window write data |
| bmRdData | output | 8 | Window read data (combinational) |
| extCmdByte | input | 16 | External command byte per channel |
| extStatByte | input | 16 | External status byte per channel |
| fwdCmdWr | output | 2 | Command-byte write pulse per channel |
| fwdStatWr | output | 2 | Status-byte write pulse per channel |
| fwdData | output | 8 | Data for forwarded writes |
| irqOut | output | 1 | Combined interrupt, registered |

## Verification
The bench first walks a table of stimulus vectors through the main behaviours. It raises and drops the request lines, masks channels through the window alias, and clears pending bits while the input is still high to see the one-cycle dip and the re-set. A design that gave the input priority would never show the dip. A design that let the alias write clear pending bits, or let configuration writes change the masks, would read back a wrong 0x71. Directed checks then cover the per-slice timing alias, forwarding, wide accesses and the unmapped bytes. A long random phase reads all three pending bytes after every step and flags any disagreement between the copies, or between irqOut and the value read back.

// File: rtl/ide_irq_pkg.sv
package ide_irq_pkg;

  localparam int NUM_CH = 2;
  localparam int BYTE_W = 8;

  // configuration-space byte addresses (decoded by software drivers)
  localparam logic [7:0] ADR_PEND_A0 = 8'h50;
  localparam logic [7:0] ADR_CH_EN   = 8'h51;
  localparam logic [7:0] ADR_PEND_A1 = 8'h57;
  localparam logic [7:0] ADR_MODE    = 8'h71;
  localparam logic [7:0] ADR_TIM0    = 8'h73;
  localparam logic [7:0] ADR_TIM1    = 8'h7B;

  // bit positions inside those bytes
  localparam int BIT_PEND_A0  = 2;
  localparam int BIT_PEND_A1  = 4;
  localparam int BIT_MODE_P0  = 2;
  localparam int BIT_MODE_P1  = 3;
  localparam int BIT_MODE_BK0 = 4;
  localparam int BIT_MODE_BK1 = 5;

  // byte lanes inside one window slice
  localparam logic [1:0] WIN_CMD  = 2'd0;
  localparam logic [1:0] WIN_MODE = 2'd1;
  localparam logic [1:0] WIN_STAT = 2'd2;
  localparam logic [1:0] WIN_TIM  = 2'd3;

  localparam logic [7:0] EN_RESET_BASE = 8'h04;
  localparam logic [7:0] EN_SECOND_BIT = 8'h08;

  typedef struct packed {
    logic [NUM_CH-1:0] pendSet;
    logic [NUM_CH-1:0] pendClr;
    logic              maskWr;
    logic [NUM_CH-1:0] maskVal;
    logic [NUM_CH-1:0] timWrCfg;
    logic [NUM_CH-1:0] timWrWin;
    logic              enWr;
    logic [BYTE_W-1:0] cfgVal;
    logic [BYTE_W-1:0] winVal;
  } ctlStrobe_t;

endpackage

// File: rtl/ide_irq_ctrl.sv
module ide_irq_ctrl
  import ide_irq_pkg::*;
#(
  parameter int CFG_AW = 8,
  parameter int WIN_AW = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] chanIrq,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic              cfgWrEn,
  input  logic [BYTE_W-1:0] cfgWrData,
  input  logic [WIN_AW-1:0] bmAddr,
  input  logic              bmWide,
  input  logic              bmWrEn,
  input  logic [BYTE_W-1:0] bmWrData,
  output ctlStrobe_t        strobe,
  output logic [NUM_CH-1:0] fwdCmdWr,
  output logic [NUM_CH-1:0] fwdStatWr,
  output logic [BYTE_W-1:0] fwdData
);

  localparam int CH_BIT = WIN_AW - 1;

  logic [NUM_CH-1:0] prevIrq;
  logic [NUM_CH-1:0] w1cReq;
  logic [NUM_CH-1:0] fallSeen;
  logic              winLegal;
  logic [1:0]        winLane;
  logic [CFG_AW-1:0] pendAdr [NUM_CH];
  logic [CFG_AW-1:0] timAdr  [NUM_CH];
  logic [BYTE_W-1:0] pendBit [NUM_CH];
  logic [BYTE_W-1:0] modeBit [NUM_CH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevIrq <= '0;
    else       prevIrq <= chanIrq;
  end

  assign winLegal = bmWrEn && !bmWide && !bmAddr[2];
  assign winLane  = bmAddr[1:0];
  assign fwdData  = bmWrData;

  assign pendAdr[0] = CFG_AW'(ADR_PEND_A0);
  assign pendAdr[1] = CFG_AW'(ADR_PEND_A1);
  assign timAdr[0]  = CFG_AW'(ADR_TIM0);
  assign timAdr[1]  = CFG_AW'(ADR_TIM1);
  assign pendBit[0] = BYTE_W'(1) << BIT_PEND_A0;
  assign pendBit[1] = BYTE_W'(1) << BIT_PEND_A1;
  assign modeBit[0] = BYTE_W'(1) << BIT_MODE_P0;
  assign modeBit[1] = BYTE_W'(1) << BIT_MODE_P1;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic sliceHit;
    assign sliceHit = winLegal && (bmAddr[CH_BIT] == 1'(ch));

    assign w1cReq[ch] = cfgWrEn &&
        (((cfgAddr == pendAdr[ch]) && |(cfgWrData & pendBit[ch])) ||
         ((cfgAddr == CFG_AW'(ADR_MODE)) && |(cfgWrData & modeBit[ch])));
    assign fallSeen[ch] = prevIrq[ch] && !chanIrq[ch];

    // a software clear beats the level; the level re-sets on the next edge
    assign strobe.pendSet[ch]  = chanIrq[ch] && !w1cReq[ch];
    assign strobe.pendClr[ch]  = w1cReq[ch] || fallSeen[ch];
    assign strobe.timWrCfg[ch] = cfgWrEn && (cfgAddr == timAdr[ch]);
    assign strobe.timWrWin[ch] = sliceHit && (winLane == WIN_TIM);
    assign fwdCmdWr[ch]        = sliceHit && (winLane == WIN_CMD);
    assign fwdStatWr[ch]       = sliceHit && (winLane == WIN_STAT);
  end

  assign strobe.maskWr  = winLegal && (winLane == WIN_MODE);
  assign strobe.maskVal = {bmWrData[BIT_MODE_BK1], bmWrData[BIT_MODE_BK0]};
  assign strobe.enWr    = cfgWrEn && (cfgAddr == CFG_AW'(ADR_CH_EN));
  assign strobe.cfgVal  = cfgWrData;
  assign strobe.winVal  = bmWrData;

  // R4: a write-one clear never coexists with a set for the same channel
  p_clr_beats_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pendClr & strobe.pendSet) == '0);

  // R2: a falling request always yields a clear on that edge
  p_fall_clears_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(chanIrq[0]) |-> strobe.pendClr[0]);

  // R9: a wide access never reaches the forwarding strobes
  p_wide_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    bmWide |-> (fwdCmdWr == '0 && fwdStatWr == '0 && !strobe.maskWr));

endmodule

// File: rtl/ide_irq_dp.sv
module ide_irq_dp
  import ide_irq_pkg::*;
#(
  parameter int CFG_AW      = 8,
  parameter int WIN_AW      = 4,
  parameter bit SECONDARY_EN = 1'b0
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctlStrobe_t             strobe,
  input  logic [CFG_AW-1:0]      cfgAddr,
  input  logic [WIN_AW-1:0]      bmAddr,
  input  logic                   bmWide,
  input  logic [NUM_CH*BYTE_W-1:0] extCmdByte,
  input  logic [NUM_CH*BYTE_W-1:0] extStatByte,
  output logic [BYTE_W-1:0]      cfgRdData,
  output logic [BYTE_W-1:0]      bmRdData,
  output logic                   irqOut
);

  localparam int CH_BIT = WIN_AW - 1;
  localparam logic [BYTE_W-1:0] EN_RESET =
      EN_RESET_BASE | (SECONDARY_EN ? EN_SECOND_BIT : 8'h00);

  logic [NUM_CH-1:0] pendCfg;   // copies held in 0x50 / 0x57
  logic [NUM_CH-1:0] pendMode;  // copies held in 0x71
  logic [NUM_CH-1:0] blkMask;
  logic [BYTE_W-1:0] chEnReg;
  logic [BYTE_W-1:0] timReg [NUM_CH];

  logic [NUM_CH-1:0] pendCfgNext, pendModeNext, blkNext;
  logic [BYTE_W-1:0] modeByte;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_pend
    always_comb begin
      pendCfgNext[ch]  = pendCfg[ch];
      pendModeNext[ch] = pendMode[ch];
      if (strobe.pendClr[ch]) begin
        pendCfgNext[ch]  = 1'b0;
        pendModeNext[ch] = 1'b0;
      end else if (strobe.pendSet[ch]) begin
        pendCfgNext[ch]  = 1'b1;
        pendModeNext[ch] = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        timReg[ch] <= '0;
      end else if (strobe.timWrCfg[ch]) begin
        timReg[ch] <= strobe.cfgVal;
      end else if (strobe.timWrWin[ch]) begin
        timReg[ch] <= strobe.winVal;
      end
    end

    // R2: a set strobe lands in both copies on the next edge
    p_set_both_r2: assert property (@(posedge clk) disable iff (!rstN)
      strobe.pendSet[ch] |=> (pendCfg[ch] && pendMode[ch]));

    // R4: a clear strobe lands in both copies on the next edge
    p_clr_both_r4: assert property (@(posedge clk) disable iff (!rstN)
      strobe.pendClr[ch] |=> (!pendCfg[ch] && !pendMode[ch]));
  end

  assign blkNext = strobe.maskWr ? strobe.maskVal : blkMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendCfg  <= '0;
      pendMode <= '0;
      blkMask  <= '0;
      chEnReg  <= EN_RESET;
      irqOut   <= 1'b0;
    end else begin
      pendCfg  <= pendCfgNext;
      pendMode <= pendModeNext;
      blkMask  <= blkNext;
      if (strobe.enWr) chEnReg <= strobe.cfgVal;
      irqOut   <= |(pendModeNext & ~blkNext);
    end
  end

  always_comb begin
    modeByte = '0;
    modeByte[BIT_MODE_P0]  = pendMode[0];
    modeByte[BIT_MODE_P1]  = pendMode[1];
    modeByte[BIT_MODE_BK0] = blkMask[0];
    modeByte[BIT_MODE_BK1] = blkMask[1];
  end

  always_comb begin
    cfgRdData = '0;
    case (cfgAddr)
      CFG_AW'(ADR_PEND_A0): cfgRdData[BIT_PEND_A0] = pendCfg[0];
      CFG_AW'(ADR_PEND_A1): cfgRdData[BIT_PEND_A1] = pendCfg[1];
      CFG_AW'(ADR_CH_EN):   cfgRdData = chEnReg;
      CFG_AW'(ADR_MODE):    cfgRdData = modeByte;
      CFG_AW'(ADR_TIM0):    cfgRdData = timReg[0];
      CFG_AW'(ADR_TIM1):    cfgRdData = timReg[1];
      default:              cfgRdData = '0;
    endcase
  end

  always_comb begin
    logic winCh;
    winCh    = bmAddr[CH_BIT];
    bmRdData = '0;
    if (bmWide) begin
      bmRdData = '1;
    end else if (!bmAddr[2]) begin
      case (bmAddr[1:0])
        WIN_CMD:  bmRdData = extCmdByte[winCh*BYTE_W +: BYTE_W];
        WIN_MODE: bmRdData = modeByte;
        WIN_STAT: bmRdData = extStatByte[winCh*BYTE_W +: BYTE_W];
        default:  bmRdData = timReg[winCh];
      endcase
    end
  end

  // R11: the two copies of every pending flag never drift apart
  p_copies_agree_r11: assert property (@(posedge clk) disable iff (!rstN)
    pendCfg == pendMode);

  // R6: masks move only on an alias write through the window
  p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.maskWr |=> $stable(blkMask));

  // R5: the registered output follows the pending and mask state
  p_irq_follows_r5: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == |(pendMode & ~blkMask));

endmodule

// File: rtl/dual_ide_irq_unit.sv
module dual_ide_irq_unit
  import ide_irq_pkg::*;
#(
  parameter int CFG_AW       = 8,
  parameter int WIN_AW       = 4,
  parameter bit SECONDARY_EN = 1'b0
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [1:0]               chanIrq,
  input  logic [CFG_AW-1:0]        cfgAddr,
  input  logic                     cfgWrEn,
  input  logic [7:0]               cfgWrData,
  output logic [7:0]               cfgRdData,
  input  logic [WIN_AW-1:0]        bmAddr,
  input  logic                     bmWide,
  input  logic                     bmWrEn,
  input  logic [7:0]               bmWrData,
  output logic [7:0]               bmRdData,
  input  logic [15:0]              extCmdByte,
  input  logic [15:0]              extStatByte,
  output logic [1:0]               fwdCmdWr,
  output logic [1:0]               fwdStatWr,
  output logic [7:0]               fwdData,
  output logic                     irqOut
);

  ctlStrobe_t strobe;

  ide_irq_ctrl #(.CFG_AW(CFG_AW), .WIN_AW(WIN_AW)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .chanIrq   (chanIrq),
    .cfgAddr   (cfgAddr),
    .cfgWrEn   (cfgWrEn),
    .cfgWrData (cfgWrData),
    .bmAddr    (bmAddr),
    .bmWide    (bmWide),
    .bmWrEn    (bmWrEn),
    .bmWrData  (bmWrData),
    .strobe    (strobe),
    .fwdCmdWr  (fwdCmdWr),
    .fwdStatWr (fwdStatWr),
    .fwdData   (fwdData)
  );

  ide_irq_dp #(.CFG_AW(CFG_AW), .WIN_AW(WIN_AW), .SECONDARY_EN(SECONDARY_EN)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .cfgAddr     (cfgAddr),
    .bmAddr      (bmAddr),
    .bmWide      (bmWide),
    .extCmdByte  (extCmdByte),
    .extStatByte (extStatByte),
    .cfgRdData   (cfgRdData),
    .bmRdData    (bmRdData),
    .irqOut      (irqOut)
  );

endmodule

// File: tb/dual_ide_irq_unit_bench.sv
module dual_ide_irq_unit_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  chanIrq = '0;
  logic [7:0]  cfgAddr = '0;
  logic        cfgWrEn = 1'b0;
  logic [7:0]  cfgWrData = '0;
  logic [7:0]  cfgRdData;
  logic [3:0]  bmAddr = '0;
  logic        bmWide = 1'b0;
  logic        bmWrEn = 1'b0;
  logic [7:0]  bmWrData = '0;
  logic [7:0]  bmRdData;
  logic [15:0] extCmdByte = 16'h1234;
  logic [15:0] extStatByte = 16'hBEEF;
  logic [1:0]  fwdCmdWr, fwdStatWr;
  logic [7:0]  fwdData;
  logic        irqOut;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  dual_ide_irq_unit u_dual_ide_irq_unit (
    .clk(clk), .rstN(rstN), .chanIrq(chanIrq),
    .cfgAddr(cfgAddr), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .bmAddr(bmAddr), .bmWide(bmWide), .bmWrEn(bmWrEn), .bmWrData(bmWrData), .bmRdData(bmRdData),
    .extCmdByte(extCmdByte), .extStatByte(extStatByte),
    .fwdCmdWr(fwdCmdWr), .fwdStatWr(fwdStatWr), .fwdData(fwdData), .irqOut(irqOut)
  );

  // vector: op(2) addr(8) data(8) chkAddr(8) expVal(8) expIrq(1)
  // op 0 = config write, 1 = window write, 2 = set request lines, 3 = idle
  localparam int NVEC = 17;
  localparam logic [34:0] VEC [NVEC] = '{
    {2'd2, 8'h00, 8'h01, 8'h71, 8'h04, 1'b1},  // R2 ch0 rises
    {2'd3, 8'h00, 8'h00, 8'h50, 8'h04, 1'b1},  // R2 copy at 0x50
    {2'd2, 8'h00, 8'h00, 8'h50, 8'h00, 1'b0},  // R2 fall clears
    {2'd2, 8'h00, 8'h02, 8'h57, 8'h10, 1'b1},  // R2 ch1 rises
    {2'd1, 8'h01, 8'h20, 8'h71, 8'h28, 1'b0},  // R6/R5 block ch1
    {2'd1, 8'h09, 8'h0C, 8'h71, 8'h08, 1'b1},  // R6 alias ignores pend bits
    {2'd0, 8'h57, 8'h10, 8'h71, 8'h00, 1'b0},  // R4 clear wins this edge
    {2'd3, 8'h00, 8'h00, 8'h57, 8'h10, 1'b1},  // R4 re-set next edge
    {2'd0, 8'h71, 8'h30, 8'h71, 8'h08, 1'b1},  // R3 masks read-only in cfg
    {2'd0, 8'h71, 8'h08, 8'h57, 8'h00, 1'b0},  // R3 clear via 0x71
    {2'd2, 8'h00, 8'h00, 8'h71, 8'h00, 1'b0},  // R2 fall
    {2'd2, 8'h00, 8'h03, 8'h71, 8'h0C, 1'b1},  // R2 both
    {2'd1, 8'h01, 8'h10, 8'h71, 8'h1C, 1'b1},  // R5 ch0 blocked, ch1 drives
    {2'd1, 8'h01, 8'h30, 8'h71, 8'h3C, 1'b0},  // R5 both blocked
    {2'd0, 8'h50, 8'h04, 8'h71, 8'h38, 1'b0},  // R3/R4 clear via 0x50
    {2'd2, 8'h00, 8'h00, 8'h71, 8'h30, 1'b0},  // R2 both fall
    {2'd1, 8'h01, 8'h00, 8'h71, 8'h00, 1'b0}   // R6 unmask
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfgRead(input logic [7:0] a, output logic [7:0] v);
    cfgAddr = a;
    #1 v = cfgRdData;
  endtask

  // apply one operation for one clock, return at the following negedge
  task automatic doOp(input logic [1:0] op, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    case (op)
      2'd0: begin cfgAddr = a; cfgWrData = d; cfgWrEn = 1'b1; end
      2'd1: begin bmAddr = a[3:0]; bmWrData = d; bmWrEn = 1'b1; end
      2'd2: chanIrq = d[1:0];
      default: ;
    endcase
    @(negedge clk);
    cfgWrEn = 1'b0;
    bmWrEn  = 1'b0;
  endtask

  initial begin
    #200000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v, a50, a57, a71;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    cfgRead(8'h51, v); check("R1 en", v, 8'h04);
    cfgRead(8'h50, v); check("R1 p0", v, 8'h00);
    cfgRead(8'h57, v); check("R1 p1", v, 8'h00);
    cfgRead(8'h71, v); check("R1 mode", v, 8'h00);
    cfgRead(8'h73, v); check("R1 tim0", v, 8'h00);
    cfgRead(8'h7B, v); check("R1 tim1", v, 8'h00);
    check("R1 irq", {7'd0, irqOut}, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      doOp(VEC[i][34:33], VEC[i][32:25], VEC[i][24:17]);
      cfgRead(VEC[i][16:9], v);
      check($sformatf("R2-R6 vec%0d reg", i), v, VEC[i][8:1]);
      check($sformatf("R5 vec%0d irq", i), {7'd0, irqOut}, {7'd0, VEC[i][0]});
    end

    // R7 timing alias per slice
    doOp(2'd1, 8'h03, 8'hA5);
    doOp(2'd1, 8'h0B, 8'h5A);
    cfgRead(8'h73, v); check("R7 tim0 cfg", v, 8'hA5);
    cfgRead(8'h7B, v); check("R7 tim1 cfg", v, 8'h5A);
    doOp(2'd0, 8'h7B, 8'h11);
    bmAddr = 4'hB; #1 check("R7 tim1 win", bmRdData, 8'h11);
    bmAddr = 4'h3; #1 check("R7 tim0 win", bmRdData, 8'hA5);

    // R8 forwarding
    @(negedge clk);
    bmAddr = 4'h8; bmWrData = 8'h77; bmWrEn = 1'b1; #1;
    check("R8 cmd strobe", {6'd0, fwdCmdWr}, 8'h02);
    check("R8 data", fwdData, 8'h77);
    bmAddr = 4'h2; #1;
    check("R8 stat strobe", {6'd0, fwdStatWr}, 8'h01);
    bmWrEn = 1'b0;
    bmAddr = 4'h8; #1 check("R8 cmd read", bmRdData, 8'h12);
    bmAddr = 4'h2; #1 check("R8 stat read", bmRdData, 8'hEF);
    bmAddr = 4'h1; #1 check("R6 alias read", bmRdData, 8'h00);

    // R9 wide access
    @(negedge clk);
    bmWide = 1'b1; bmAddr = 4'h1; #1 check("R9 wide read", bmRdData, 8'hFF);
    bmAddr = 4'h0; bmWrEn = 1'b1; bmWrData = 8'h33; #1;
    check("R9 no fwd", {6'd0, fwdCmdWr}, 8'h00);
    bmAddr = 4'h1; bmWrData = 8'h30;
    @(negedge clk);
    bmWrEn = 1'b0; bmWide = 1'b0;
    cfgRead(8'h71, v); check("R9 mask kept", v, 8'h00);
    bmAddr = 4'h3; bmWide = 1'b1; bmWrEn = 1'b1; bmWrData = 8'hEE;
    @(negedge clk);
    bmWrEn = 1'b0; bmWide = 1'b0;
    cfgRead(8'h73, v); check("R9 tim kept", v, 8'hA5);

    // R10 enable byte and unmapped bytes
    doOp(2'd0, 8'h51, 8'h0C);
    cfgRead(8'h51, v); check("R10 en write", v, 8'h0C);
    cfgRead(8'h60, v); check("R10 unmapped", v, 8'h00);
    bmAddr = 4'h5; #1 check("R10 win hole", bmRdData, 8'h00);

    // R11 / R5 random consistency
    for (int k = 0; k < 400; k++) begin
      int sel;
      sel = $urandom_range(0, 4);
      case (sel)
        0: doOp(2'd2, 8'h00, 8'($urandom_range(0, 3)));
        1: doOp(2'd0, 8'h50, 8'($urandom));
        2: doOp(2'd0, 8'h57, 8'($urandom));
        3: doOp(2'd0, 8'h71, 8'($urandom));
        default: doOp(2'd1, {4'd0, 1'($urandom), 3'd1}, 8'($urandom));
      endcase
      cfgRead(8'h50, a50);
      cfgRead(8'h57, a57);
      cfgRead(8'h71, a71);
      check("R11 ch0 copies", {7'd0, a50[2]}, {7'd0, a71[2]});
      check("R11 ch1 copies", {7'd0, a57[4]}, {7'd0, a71[3]});
      check("R5 irq formula", {7'd0, irqOut},
            {7'd0, (a71[2] & ~a71[4]) | (a71[3] & ~a71[5])});
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule